// File: doc/BRIEF.md
# Sequential Radix-4 Booth Signed Multiplier

This block multiplies two 32-bit two's-complement numbers and returns the 64-bit signed product as a high word and a low word. It works iteratively and retires two multiplier bits per clock. Each step recodes a three-bit window into a signed digit in the set {-2, -1, 0, +1, +2}. That digit decides whether the stored multiplicand, or twice its value, is added to or subtracted from the running upper half. The running upper half lives in a 34-bit sign-extended adder path. After each add, the high/low register pair shifts right arithmetically by two places.

A caller presents both operands together with a one-cycle start strobe while the block is idle. The block then runs sixteen steps with busy raised. It pulses done for one cycle when the product is in place, and the product stays on the outputs until the next accepted start. A start that arrives during a run is not accepted.

Top module: `booth_mul_seq`

## Requirements
- R1: While reset is held and right after it, busy, done, hi and lo are all zero.
- R2: A start seen while busy is low is accepted at that clock edge. From the next cycle, busy is high, the high word is zero and the low word holds the multiplier.
- R3: An accepted start is followed by exactly sixteen steps. On the sixteenth step edge busy falls and done rises, which is the 17th rising edge counting the accept edge as the first. Done lasts exactly one cycle, and done and busy are never high together.
- R4: When done is high, {hi, lo} equals the signed 64-bit product of the accepted multiplicand and multiplier, with hi holding bits 63..32.
- R5: The extreme operand pairs give exact results: -2^31 × -2^31 gives hi=0x40000000, lo=0; -2^31 × 1, 0 × x, -1 × -1 and the maximum positive value times -2^31 are also exact.
- R6: A start raised while busy is high has no effect. The run in progress keeps its operands, its done time and its product, and no extra done pulse follows.
- R7: After done, hi and lo keep their values until the next accepted start.
- R8: Each step recodes the window {lo[1], lo[0], previous bit}, with the previous bit zero at start, as follows: 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0. A zero digit leaves the partial sum equal to the sign-extended high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, accepted only while idle |
| mcand | input | 32 | Multiplicand, two's complement |
| mplier | input | 32 | Multiplier, two's complement |
| busy | output | 1 | High while a product is being formed |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | 32 | Upper 32 bits of the product |
| lo | output | 32 | Lower 32 bits of the product |

## Verification
The case hardest to reach from the ports is a run where the +2 and -2 digits meet a multiplicand of -2^31. Doubling that multiplicand needs the two extra adder bits, and a sign error there only shows when the same digit repeats across many steps. The stimulus forces this with alternating and paired-bit multiplier patterns (0x55555555, 0xAAAAAAAA, 0x33333333, 0xCCCCCCCC) against the extreme multiplicands, in addition to random pairs. A second hard case is a start strobe in the middle of a run: the bench raises one with different operands and then checks that the product and the done cycle of the first run are unchanged.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef struct packed {
        logic skip;   // digit is zero
        logic dbl;    // use twice the multiplicand
        logic neg;    // subtract instead of add
    } booth_ctl_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic [2:0]  grp,   // {lo[1], lo[0], prev}
    output booth_ctl_t  ctl
);
    always_comb begin
        ctl = '0;
        unique case (grp)
            3'b000: ctl.skip = 1'b1;
            3'b001: ctl      = '{skip: 1'b0, dbl: 1'b0, neg: 1'b0};
            3'b010: ctl      = '{skip: 1'b0, dbl: 1'b0, neg: 1'b0};
            3'b011: ctl      = '{skip: 1'b0, dbl: 1'b1, neg: 1'b0};
            3'b100: ctl      = '{skip: 1'b0, dbl: 1'b1, neg: 1'b1};
            3'b101: ctl      = '{skip: 1'b0, dbl: 1'b0, neg: 1'b1};
            3'b110: ctl      = '{skip: 1'b0, dbl: 1'b0, neg: 1'b1};
            default: ctl.skip = 1'b1;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]  acc,
    input  logic [W-1:0]  mc,
    input  booth_ctl_t    ctl,
    output logic [W+1:0]  sum
);
    localparam int XW = W + 2;

    logic [XW-1:0] acc_x;
    logic [XW-1:0] mc_x;
    logic [XW-1:0] opnd;
    logic [XW-1:0] opnd_inv;

    always_comb begin
        acc_x    = {{2{acc[W-1]}}, acc};
        mc_x     = {{2{mc[W-1]}}, mc};
        opnd     = ctl.skip ? '0 : (ctl.dbl ? {mc_x[XW-2:0], 1'b0} : mc_x);
        opnd_inv = ctl.neg ? ~opnd : opnd;
        sum      = acc_x + opnd_inv + {{(XW-1){1'b0}}, ctl.neg};
    end
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  mcand,
    input  logic [W-1:0]  mplier,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  hi,
    output logic [W-1:0]  lo
);
    localparam int STEPS = W / 2;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic          prev;
        logic [W-1:0]  mc;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
    } state_t;

    state_t      s_q, s_d;
    booth_ctl_t  ctl;
    logic [W+1:0] sum;

    booth_recode u_rec (
        .grp (({s_q.lo[1:0], s_q.prev})),
        .ctl (ctl)
    );

    booth_addsub #(.W(W)) u_add (
        .acc (s_q.hi),
        .mc  (s_q.mc),
        .ctl (ctl),
        .sum (sum)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy && start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.prev = 1'b0;
            s_d.mc   = mcand;
            s_d.hi   = '0;
            s_d.lo   = mplier;
        end else if (s_q.busy) begin
            s_d.hi   = sum[W+1:2];
            s_d.lo   = {sum[1:0], s_q.lo[W-1:2]};
            s_d.prev = s_q.lo[1];
            s_d.cnt  = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign hi   = s_q.hi;
    assign lo   = s_q.lo;

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_done_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && hi == '0 && lo == $past(mplier)));
    p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(s_q.mc));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(hi) && $stable(lo)));
    p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl.skip) |-> (sum == {{2{hi[W-1]}}, hi}));
endmodule

// File: tb/sim_booth_mul_seq.sv
`timescale 1ns/1ps
module sim_booth_mul_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mcand = '0;
    logic [31:0] mplier = '0;
    logic        busy, done;
    logic [31:0] hi, lo;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [63:0] last_prod = '0;

    typedef struct {
        logic [63:0] prod;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    booth_mul_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6 unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({hi, lo} == e.prod, e.tag, {hi, lo}, e.prod);
                check(cyc == e.due, "R3 done cycle", 64'(cyc), 64'(e.due));
                check(!busy, "R3 busy low with done", 64'(busy), 64'd0);
                last_prod = e.prod;
            end
        end
    end

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input string tag);
        exp_t e;
        logic signed [63:0] sa, sb;
        while (busy) @(negedge clk);
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        e.prod = 64'(sa * sb);
        e.due  = cyc + 17;
        e.tag  = tag;
        sb_q.push_back(e);
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        check({hi, lo} == {32'd0, b}, "R2 load state", {hi, lo}, {32'd0, b});
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1;
        check({busy, done, hi, lo} == '0, "R1 in reset", {hi, lo}, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, hi, lo} == '0, "R1 after reset", {hi, lo}, 64'd0);

        // R5 corner operands
        issue(32'h8000_0000, 32'h8000_0000, "R5 min*min");
        issue(32'h8000_0000, 32'h0000_0001, "R5 min*1");
        issue(32'h0000_0000, 32'h1234_5678, "R5 0*x");
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 -1*-1");
        issue(32'h7FFF_FFFF, 32'h8000_0000, "R5 max*min");
        issue(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R5 max*max");
        issue(32'h1234_5678, 32'h0000_0000, "R5 x*0");
        wait_idle();

        // R7 hold after done
        repeat (4) @(negedge clk);
        check({hi, lo} == last_prod, "R7 hold after done", {hi, lo}, last_prod);

        // R8 digit patterns against extreme multiplicands
        foreach (sb_q[i]) begin end
        begin
            logic [31:0] pats [4] = '{32'h5555_5555, 32'hAAAA_AAAA, 32'h3333_3333, 32'hCCCC_CCCC};
            logic [31:0] mcs  [3] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFD};
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 3; j++)
                    issue(mcs[j], pats[i], "R8 digit pattern");
        end

        // R6 start while busy
        wait_idle();
        issue(32'h0000_0123, 32'hFFFF_FF00, "R6 product kept");
        repeat (4) @(negedge clk);
        start = 1'b1; mcand = 32'h7777_7777; mplier = 32'h0000_0002;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R6 still busy", 64'(busy), 64'd1);
        wait_idle();
        repeat (20) @(negedge clk);
        check(sb_q.size() == 0 && !busy, "R6 no extra run", 64'(busy), 64'd0);

        // R4 random operands
        for (int k = 0; k < 40; k++)
            issue($urandom, $urandom, "R4 random");
        wait_idle();
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R4 scoreboard drained", 64'(sb_q.size()), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule